// File: doc/BRIEF.md
# Daisy-chained SPI command node

This block is the command endpoint inside one hashing chip. Several such chips are wired in a serial chain on an SPI mode 1 link. The block works on whole 16-bit words. A separate bit shifter, outside this block, raises `word_vld` once per received word. On each strobe the node registers one word toward the next chip. Most words pass through unchanged, so every chip adds exactly one word of delay. When a command is addressed to the node, the node substitutes its own reply words in the stream.

A command starts with a header word. The high byte of the header is the opcode and the low byte is the target chip id, where id 0 means every chip. The host gives the chips their ids with an enumeration command. After that it can:
- program the clock configuration,
- read back a status record,
- load hashing jobs,
- poll a small queue of found nonces,
- clear the queues.

The hashing cores and the clock generator sit outside the block. Jobs leave as a word stream with an acceptance pulse. Results enter through a push port.

Top module: `chain_cmd_node`

## Requirements
- R1: Every word the node does not replace appears on `word_out` one strobe after it arrived, unchanged. `word_out` holds its value between strobes. After reset `word_out`, `chip_id`, `pll_cfg` and `job_start` are 0.
- R2: Enumeration is header 0x0100 followed by a count word. On its first enumeration the node takes id = count low byte + 1 and forwards {0x00, id}. On any later enumeration it forwards 0x0000 in place of the count and keeps its id. Three fresh chips therefore return 0x0003.
- R3: Register write is header 0x09<id> followed by three payload words. If the id matches or is 0, the first payload word becomes `pll_cfg`. Payload words are never taken as headers by any chip.
- R4: Register read 0x0A<own id> is answered with header 0x1A<id> and then three words: `pll_cfg`; {7'b0, pll_lock, 6'b0, slots_full, core_busy}; {0x00, core_count}.
- R5: A result poll is 0x08 with id 0 or the own id. With a non-empty queue the node answers {0, tag[2:0], 4'h8, id} and then the nonce as a high word and a low word, oldest entry first, and removes that entry. With an empty queue the header passes unchanged, so 0x0800 is the empty marker.
- R6: The result queue holds RES_DEPTH entries. A push into a full queue is dropped.
- R7: A job is header {0, tag[2:0], 4'h7, id} followed by 28 words. If the id matches, the tag is 1..4 and a slot is free, the node pulses `job_word_vld` with each payload word and pulses `job_start` with `job_tag` on the last one.
- R8: At most JOB_SLOTS jobs are held. A job that arrives while all slots are taken produces no job output. A `core_take` pulse frees one slot.
- R9: Reset opcode 0x04 (own id or 0) empties the result queue and the job slots. The chip id is kept.
- R10: A reply from another chip (0x1A header, or a result header with a non-zero tag) passes through unchanged together with its payload words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | One-cycle strobe: a chain word is present |
| word_in | input | 16 | Word from the previous chip or the host |
| word_out | output | 16 | Registered word toward the next chip |
| chip_id | output | 8 | Id assigned by enumeration (0 = unassigned) |
| pll_cfg | output | 16 | Clock configuration word |
| pll_lock | input | 1 | Clock generator is locked |
| core_busy | input | 1 | Cores are hashing |
| core_count | input | 8 | Number of active cores |
| core_take | input | 1 | Cores have taken one job, so a slot is freed |
| job_word_vld | output | 1 | Job payload word valid |
| job_word | output | 16 | Job payload word |
| job_start | output | 1 | Job fully received and accepted |
| job_tag | output | 3 | Tag of the current job |
| res_push | input | 1 | Store one result |
| res_tag | input | 3 | Job tag of the result |
| res_nonce | input | 32 | Nonce of the result |

## Verification
A wrong parse state shows within a single strobe. Payload bytes taken as a header cause a reply or a replacement that can be seen downstream. Skipping too few or too many words shifts every later reply by one word slot. The bench drives a chain of three nodes and places commands and look-alike payload words in the stream, so a miscount shows up as a misplaced word at the chain end. Queue and slot errors show on the next status read or result poll: a wrong order, a lost entry or a stuck full flag.

// File: rtl/cmdn_pkg.sv
package cmdn_pkg;
    localparam logic [7:0] OP_ENUM      = 8'h01;
    localparam logic [7:0] OP_RESET     = 8'h04;
    localparam logic [3:0] OP_JOB_NIB   = 4'h7;
    localparam logic [3:0] OP_RES_NIB   = 4'h8;
    localparam logic [7:0] OP_RESULT    = 8'h08;
    localparam logic [7:0] OP_WRREG     = 8'h09;
    localparam logic [7:0] OP_RDREG     = 8'h0a;
    localparam logic [7:0] OP_RDREG_ACK = 8'h1a;
    localparam logic [7:0] BCAST_ID     = 8'h00;

    typedef enum logic [2:0] {
        M_HDR, M_SKIP, M_WREG, M_JOB, M_ENUM, M_RDREG, M_RDRES
    } mode_e;
endpackage

// File: rtl/cmdn_result_fifo.sv
module cmdn_result_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         clr,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = ptr_next(st_q.wr);
            end
            if (do_pop) st_d.rd = ptr_next(st_q.rd);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
endmodule

// File: rtl/cmdn_reply_build.sv
module cmdn_reply_build (
    input  logic [15:0] pll_cfg,
    input  logic        pll_lock,
    input  logic        core_busy,
    input  logic        slots_full,
    input  logic [7:0]  core_count,
    input  logic [31:0] nonce,
    input  logic [1:0]  rem,
    output logic [15:0] reg_word,
    output logic [15:0] res_word
);
    // rem counts the reply words still to send: 3 = first register word.
    always_comb begin
        case (rem)
            2'd3:    reg_word = pll_cfg;
            2'd2:    reg_word = {7'b0, pll_lock, 6'b0, slots_full, core_busy};
            default: reg_word = {8'h00, core_count};
        endcase
        res_word = (rem == 2'd2) ? nonce[31:16] : nonce[15:0];
    end
endmodule

// File: rtl/chain_cmd_node.sv
module chain_cmd_node
    import cmdn_pkg::*;
#(
    parameter int          JOB_SLOTS = 2,
    parameter int          RES_DEPTH = 4,
    parameter int          JOB_WORDS = 28,
    parameter logic [15:0] PLL_RST   = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_vld,
    input  logic [15:0] word_in,
    output logic [15:0] word_out,
    output logic [7:0]  chip_id,
    output logic [15:0] pll_cfg,
    input  logic        pll_lock,
    input  logic        core_busy,
    input  logic [7:0]  core_count,
    input  logic        core_take,
    output logic        job_word_vld,
    output logic [15:0] job_word,
    output logic        job_start,
    output logic [2:0]  job_tag,
    input  logic        res_push,
    input  logic [2:0]  res_tag,
    input  logic [31:0] res_nonce
);
    localparam int REG_WORDS   = 3;
    localparam int NONCE_WORDS = 2;
    localparam int CW = $clog2(JOB_WORDS + 1);
    localparam int SW = $clog2(JOB_SLOTS + 1);
    localparam int RW = 3 + 32;

    typedef struct packed {
        mode_e          mode;
        logic [CW-1:0]  cnt;
        logic           hit;
        logic [7:0]     id;
        logic           enum_done;
        logic [15:0]    pll;
        logic [31:0]    nonce;
        logic [SW-1:0]  slots;
        logic [2:0]     tag;
        logic [15:0]    out;
        logic           jvld;
        logic [15:0]    jword;
        logic           jstart;
    } node_st_t;

    node_st_t st_d, st_q;

    logic          fifo_pop, fifo_clr, fifo_empty;
    logic [RW-1:0] fifo_head;
    logic [15:0]   reg_word, res_word;
    logic          slots_full;
    logic [7:0]    cmd, tid;
    logic          for_me, bcast, inc, dec;

    assign slots_full = (st_q.slots == SW'(JOB_SLOTS));

    cmdn_result_fifo #(.DEPTH(RES_DEPTH), .W(RW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (res_push),
        .din   ({res_tag, res_nonce}),
        .pop   (fifo_pop),
        .clr   (fifo_clr),
        .empty (fifo_empty),
        .head  (fifo_head)
    );

    cmdn_reply_build u_reply (
        .pll_cfg    (st_q.pll),
        .pll_lock   (pll_lock),
        .core_busy  (core_busy),
        .slots_full (slots_full),
        .core_count (core_count),
        .nonce      (st_q.nonce),
        .rem        (st_q.cnt[1:0]),
        .reg_word   (reg_word),
        .res_word   (res_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.jvld   = 1'b0;
        st_d.jstart = 1'b0;
        fifo_pop    = 1'b0;
        fifo_clr    = 1'b0;
        inc         = 1'b0;
        cmd         = word_in[15:8];
        tid         = word_in[7:0];
        bcast       = (tid == BCAST_ID);
        for_me      = st_q.enum_done && (tid == st_q.id);
        dec         = core_take && (st_q.slots != '0);

        if (word_vld) begin
            st_d.out = word_in;
            case (st_q.mode)
                M_HDR: begin
                    if (cmd == OP_ENUM && bcast) begin
                        st_d.mode = M_ENUM;
                    end else if (cmd == OP_WRREG) begin
                        st_d.mode = M_WREG;
                        st_d.cnt  = CW'(REG_WORDS);
                        st_d.hit  = for_me || bcast;
                    end else if (cmd == OP_RDREG && for_me) begin
                        st_d.out  = {OP_RDREG_ACK, st_q.id};
                        st_d.mode = M_RDREG;
                        st_d.cnt  = CW'(REG_WORDS);
                    end else if (cmd == OP_RDREG_ACK) begin
                        st_d.mode = M_SKIP;
                        st_d.cnt  = CW'(REG_WORDS);
                    end else if (cmd == OP_RESULT && (for_me || bcast) && !fifo_empty) begin
                        st_d.out   = {1'b0, fifo_head[RW-1:32], OP_RES_NIB, st_q.id};
                        st_d.nonce = fifo_head[31:0];
                        fifo_pop   = 1'b1;
                        st_d.mode  = M_RDRES;
                        st_d.cnt   = CW'(NONCE_WORDS);
                    end else if (cmd[3:0] == OP_RES_NIB && cmd[7:4] != 4'h0) begin
                        st_d.mode = M_SKIP;
                        st_d.cnt  = CW'(NONCE_WORDS);
                    end else if (cmd[3:0] == OP_JOB_NIB && cmd[7:4] <= 4'd4) begin
                        st_d.mode = M_JOB;
                        st_d.cnt  = CW'(JOB_WORDS);
                        st_d.tag  = cmd[6:4];
                        st_d.hit  = for_me && (cmd[7:4] != 4'h0) && !slots_full;
                    end else if (cmd == OP_RESET && (for_me || bcast)) begin
                        fifo_clr = 1'b1;
                    end
                end
                M_ENUM: begin
                    if (!st_q.enum_done) begin
                        st_d.id        = word_in[7:0] + 8'd1;
                        st_d.enum_done = 1'b1;
                        st_d.out       = {8'h00, word_in[7:0] + 8'd1};
                    end else begin
                        st_d.out = 16'h0000;
                    end
                    st_d.mode = M_HDR;
                end
                default: begin
                    case (st_q.mode)
                        M_WREG:  if (st_q.hit && st_q.cnt == CW'(REG_WORDS)) st_d.pll = word_in;
                        M_RDREG: st_d.out = reg_word;
                        M_RDRES: st_d.out = res_word;
                        M_JOB: begin
                            if (st_q.hit) begin
                                st_d.jvld  = 1'b1;
                                st_d.jword = word_in;
                                if (st_q.cnt == CW'(1)) begin
                                    st_d.jstart = 1'b1;
                                    inc         = 1'b1;
                                end
                            end
                        end
                        default: ;
                    endcase
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == CW'(1)) st_d.mode = M_HDR;
                end
            endcase
        end

        if (fifo_clr) st_d.slots = '0;
        else          st_d.slots = st_q.slots + SW'(inc) - SW'(dec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= M_HDR;
            st_q.pll  <= PLL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out     = st_q.out;
    assign chip_id      = st_q.id;
    assign pll_cfg      = st_q.pll;
    assign job_word_vld = st_q.jvld;
    assign job_word     = st_q.jword;
    assign job_start    = st_q.jstart;
    assign job_tag      = st_q.tag;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(word_out));
    assert_id_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.enum_done |=> $stable(st_q.id));
    assert_tag_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> (job_tag != 3'd0 && job_tag <= 3'd4));
    assert_slots_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slots <= SW'(JOB_SLOTS));
endmodule

// File: tb/tb_chain_cmd_node.sv
`timescale 1ns/1ps
module tb_chain_cmd_node;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        word_vld = 1'b0;
    logic [15:0] host_w = 16'h0;
    logic [15:0] w01, w12, last_w;

    logic        pll_lock = 1'b1, core_busy = 1'b0, core_take = 1'b0;
    logic [7:0]  core_count = 8'd6;
    logic        res_push = 1'b0;
    logic [2:0]  res_tag = 3'd0;
    logic [31:0] res_nonce = 32'h0;

    logic [7:0]  dut_id, u0_id, u1_id;
    logic [15:0] dut_pll, u0_pll, u1_pll, dut_jw, u0_jw, u1_jw;
    logic        dut_jv, dut_js, u0_jv, u0_js, u1_jv, u1_js;
    logic [2:0]  dut_tag, u0_tag, u1_tag;

    chain_cmd_node u_up0 (.clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(host_w),
        .word_out(w01), .chip_id(u0_id), .pll_cfg(u0_pll), .pll_lock(1'b0), .core_busy(1'b0),
        .core_count(8'd4), .core_take(1'b0), .job_word_vld(u0_jv), .job_word(u0_jw),
        .job_start(u0_js), .job_tag(u0_tag), .res_push(1'b0), .res_tag(3'd0), .res_nonce(32'h0));
    chain_cmd_node u_up1 (.clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(w01),
        .word_out(w12), .chip_id(u1_id), .pll_cfg(u1_pll), .pll_lock(1'b0), .core_busy(1'b0),
        .core_count(8'd4), .core_take(1'b0), .job_word_vld(u1_jv), .job_word(u1_jw),
        .job_start(u1_js), .job_tag(u1_tag), .res_push(1'b0), .res_tag(3'd0), .res_nonce(32'h0));
    chain_cmd_node dut (.clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(w12),
        .word_out(last_w), .chip_id(dut_id), .pll_cfg(dut_pll), .pll_lock(pll_lock),
        .core_busy(core_busy), .core_count(core_count), .core_take(core_take),
        .job_word_vld(dut_jv), .job_word(dut_jw), .job_start(dut_js), .job_tag(dut_tag),
        .res_push(res_push), .res_tag(res_tag), .res_nonce(res_nonce));

    int checks = 0, fails = 0;
    int jw_cnt = 0, js_cnt = 0;
    logic [15:0] last_jw = 16'h0;
    logic [2:0]  last_tag = 3'd0;
    logic        done = 1'b0;
    logic [15:0] seq_o [6];

    always @(negedge clk) begin
        if (dut_jv) begin jw_cnt++; last_jw = dut_jw; end
        if (dut_js) begin js_cnt++; last_tag = dut_tag; end
    end

    // {req, host word, expected word at chain end after that strobe}; dut is chip 3
    localparam int TBL_N = 32;
    localparam logic [39:0] VEC [TBL_N] = '{
        // R2 first enumeration
        {8'd2,16'h0100,16'h0000}, {8'd2,16'h0000,16'h0000}, {8'd2,16'h0000,16'h0100},
        {8'd2,16'h0000,16'h0003}, {8'd2,16'h0000,16'h0000},
        // R2 second enumeration reports 0
        {8'd2,16'h0100,16'h0000}, {8'd2,16'h0000,16'h0000}, {8'd2,16'h0000,16'h0100},
        {8'd2,16'h0000,16'h0000}, {8'd2,16'h0000,16'h0000},
        // R3 register write with look-alike payload, R1 forwarding
        {8'd3,16'h0903,16'h0000}, {8'd3,16'h1234,16'h0000}, {8'd3,16'h0400,16'h0903},
        {8'd3,16'h0a03,16'h1234}, {8'd3,16'h0000,16'h0400}, {8'd3,16'h0000,16'h0a03},
        // R4 register read of chip 3
        {8'd4,16'h0a03,16'h0000}, {8'd4,16'h0000,16'h0000}, {8'd4,16'h0000,16'h1a03},
        {8'd4,16'h0000,16'h1234}, {8'd4,16'h0000,16'h0100}, {8'd4,16'h0000,16'h0006},
        // R10 reply from chip 2 passes the dut
        {8'd10,16'h0a02,16'h0000}, {8'd10,16'h0000,16'h0000}, {8'd10,16'h0000,16'h1a02},
        {8'd10,16'h0000,16'h0000}, {8'd10,16'h0000,16'h0000}, {8'd10,16'h0000,16'h0004},
        // R5 empty result marker
        {8'd5,16'h0800,16'h0000}, {8'd5,16'h0000,16'h0000}, {8'd5,16'h0000,16'h0800},
        {8'd5,16'h0000,16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, output logic [15:0] o);
        @(negedge clk);
        word_vld = 1'b1;
        host_w   = w;
        @(negedge clk);
        word_vld = 1'b0;
        host_w   = 16'h0;
        o = last_w;
    endtask

    task automatic run_seq(input logic [15:0] h);
        logic [15:0] o;
        xfer(h, o);
        seq_o[0] = o;
        for (int i = 1; i < 6; i++) begin
            xfer(16'h0000, o);
            seq_o[i] = o;
        end
    endtask

    task automatic push_res(input logic [2:0] t, input logic [31:0] n);
        @(negedge clk);
        res_push = 1'b1; res_tag = t; res_nonce = n;
        @(negedge clk);
        res_push = 1'b0;
    endtask

    task automatic send_job(input logic [2:0] t);
        logic [15:0] o;
        xfer({1'b0, t, 4'h7, 8'h03}, o);
        for (int i = 0; i < 28; i++) xfer(16'h5000 + 16'(i), o);
        for (int i = 0; i < 4; i++) xfer(16'h0000, o);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset word_out", 32'(last_w), 32'h0);
        chk("R1 reset chip_id", 32'(dut_id), 32'h0);
        chk("R1 reset pll_cfg", 32'(dut_pll), 32'h0);
        chk("R1 reset job_start", 32'(dut_js), 32'h0);

        for (int i = 0; i < TBL_N; i++) begin
            xfer(VEC[i][31:16], o);
            chk($sformatf("R%0d table[%0d]", VEC[i][39:32], i), 32'(o), 32'(VEC[i][15:0]));
        end
        // R1 output holds with no strobe
        repeat (4) @(negedge clk);
        chk("R1 hold", 32'(last_w), 32'h0);
        chk("R2 chip id", 32'(dut_id), 32'd3);
        chk("R3 pll_cfg", 32'(dut_pll), 32'h1234);

        // R5 tagged result, then empty
        push_res(3'd2, 32'hDEADBEEF);
        run_seq(16'h0800);
        chk("R5 result header", 32'(seq_o[2]), 32'h2803);
        chk("R5 nonce high", 32'(seq_o[3]), 32'hDEAD);
        chk("R5 nonce low", 32'(seq_o[4]), 32'hBEEF);
        run_seq(16'h0800);
        chk("R5 empty after pop", 32'(seq_o[2]), 32'h0800);

        // R6 overflow drops the fifth push, order kept
        for (int k = 1; k <= 5; k++) push_res(3'(k), 32'hA0000000 + 32'(k));
        for (int k = 1; k <= 4; k++) begin
            run_seq(16'h0800);
            chk($sformatf("R6 header %0d", k), 32'(seq_o[2]), 32'({1'b0, 3'(k), 4'h8, 8'h03}));
            chk($sformatf("R6 nonce low %0d", k), 32'(seq_o[4]), 32'(k));
        end
        run_seq(16'h0800);
        chk("R6 dropped entry", 32'(seq_o[2]), 32'h0800);

        // R7 job accepted
        send_job(3'd1);
        chk("R7 job words", 32'(jw_cnt), 32'd28);
        chk("R7 job start", 32'(js_cnt), 32'd1);
        chk("R7 job tag", 32'(last_tag), 32'd1);
        chk("R7 last job word", 32'(last_jw), 32'h501B);

        // R8 slots full
        send_job(3'd2);
        run_seq(16'h0a03);
        chk("R8 full flag", 32'(seq_o[4]), 32'h0102);
        send_job(3'd3);
        chk("R8 ignored job start", 32'(js_cnt), 32'd2);
        chk("R8 ignored job words", 32'(jw_cnt), 32'd56);
        @(negedge clk); core_take = 1'b1;
        @(negedge clk); core_take = 1'b0;
        run_seq(16'h0a03);
        chk("R8 slot freed", 32'(seq_o[4]), 32'h0100);

        // R9 reset command clears queues, keeps id
        push_res(3'd3, 32'h12345678);
        send_job(3'd4);
        chk("R7 second accept tag", 32'(last_tag), 32'd4);
        run_seq(16'h0400);
        run_seq(16'h0a03);
        chk("R9 id kept", 32'(seq_o[2]), 32'h1a03);
        chk("R9 slots cleared", 32'(seq_o[4]), 32'h0100);
        run_seq(16'h0800);
        chk("R9 queue cleared", 32'(seq_o[2]), 32'h0800);
        chk("R9 chip_id port", 32'(dut_id), 32'd3);

        finish_run();
    end
endmodule